// File: doc/BRIEF.md
# Acquisition Cycle and Bunch-Crossing Numbering Unit

This unit holds the numbers that let data recorded by several detector subsystems be matched up afterwards. It runs on the fast clock and sees a one-cycle `startAcq` pulse each time an acquisition cycle begins. It keeps a cycle number that stays at zero for the very first cycle and steps by one on each later start. Within the current cycle it counts bunch-crossing periods. A period is one tick of the master bunch-crossing rate, made by dividing the fast clock by `DIV` (ten by default, so 50 MHz gives 5 MHz). The divider phase is realigned on every start, so each subsystem sees the same fixed offset.

When the unit is built with a spill counter, it also counts rising edges of a beam-spill level input. A host clear resets every counter in the same cycle. The counts and a small status word are read through a read-only, address-selected data port. A request strobe returns a one-cycle event strobe carrying the current cycle number, so that downstream logic can tag a record with it.

Top module: `acq_bx_counter`

## Requirements
- R1: After `rstN` is released, or on the edge after `hostClear` is high, the cycle count, bunch-crossing count, spill count, overflow flag and running flag are all zero.
- R2: The first `startAcq` after reset or clear leaves the cycle count at 0 and sets the running flag (status bit 1).
- R3: Each later `startAcq` increments the cycle count by one, modulo 2^`AC_W` (`AC_W` is 16 by default and at least 16). Without a start, the cycle count holds.
- R4: On a `startAcq` the bunch-crossing count becomes 0. After j further clock edges it reads floor(j/`DIV`), provided it is below its maximum.
- R5: Before the first `startAcq` (running flag clear), the bunch-crossing count stays at 0.
- R6: The bunch-crossing count saturates at 2^`BX_W`-1. A tick arriving at that value sets a sticky overflow flag (status bit 0), which only a `startAcq`, `hostClear` or reset clears.
- R7: The spill count increments once per rising edge of `spillIn`. Holding `spillIn` high or low adds nothing.
- R8: One cycle after `evtReq` is high, `evtValid` is high and `evtCycle` equals the cycle count as it was in the request cycle. Otherwise `evtValid` is low.
- R9: `rdData` shows, zero-extended, the cycle count at `rdAddr`=0, the bunch-crossing count at 1, the spill count at 2 and the status word at 3.
- R10: When `hostClear` and `startAcq` are high in the same cycle, the clear wins: every count stays zero and the running flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostClear | input | 1 | Synchronous clear of all counters |
| startAcq | input | 1 | One-cycle acquisition start pulse |
| spillIn | input | 1 | Beam-spill level, synchronous to clk |
| evtReq | input | 1 | Request an event strobe tagged with the cycle number |
| rdAddr | input | 2 | Register select |
| rdData | output | DATA_W | Selected register, zero-extended |
| evtValid | output | 1 | Event strobe, one cycle after a request |
| evtCycle | output | AC_W | Cycle number attached to the event strobe |

## Verification
A wrong divider phase shows up as a bunch-crossing count that is off by one at a multiple of `DIV` edges after a start. This is visible within ten cycles of any start. A missing first-cycle guard shows a cycle count of 1 right after the first start, and a wrong spill edge detector shows extra counts while the spill level is held. The overflow flag is observed through the status word once the count is held at its ceiling. The event tag is compared with the cycle count one cycle after the request.

// File: rtl/acqcnt_pkg.sv
package acqcnt_pkg;

  // Strobes issued by the control section to the counting datapath
  typedef struct packed {
    logic clearAll;      // host clear, wins over everything
    logic cycleStart;    // a start pulse that is not overridden
    logic advanceCycle;  // a start that moves the cycle number
    logic bxTick;        // one master-clock period elapsed
    logic spillRise;     // rising edge of the spill level
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_CYCLE  = 2'd0;
  localparam logic [1:0] ADDR_BX     = 2'd1;
  localparam logic [1:0] ADDR_SPILL  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

endpackage

// File: rtl/acqcnt_ctrl.sv
module acqcnt_ctrl
  import acqcnt_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostClear,
  input  logic        startAcq,
  input  logic        spillIn,
  output ctrlStrobe_t strb,
  output logic        running
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] divCnt;
  logic          spillPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      divCnt    <= '0;
      spillPrev <= 1'b0;
    end else begin
      spillPrev <= spillIn;
      if (hostClear) begin
        running <= 1'b0;
        divCnt  <= '0;
      end else if (startAcq) begin
        running <= 1'b1;
        divCnt  <= '0;
      end else if (running) begin
        divCnt <= (divCnt == LAST) ? '0 : divCnt + DW'(1);
      end
    end
  end

  always_comb begin
    strb.clearAll     = hostClear;
    strb.cycleStart   = startAcq && !hostClear;
    strb.advanceCycle = startAcq && !hostClear && running;
    strb.bxTick       = running && !hostClear && !startAcq && (divCnt == LAST);
    strb.spillRise    = spillIn && !spillPrev && !hostClear;
  end

endmodule

// File: rtl/acqcnt_datapath.sv
module acqcnt_datapath
  import acqcnt_pkg::*;
#(
  parameter int AC_W     = 16,
  parameter int BX_W     = 16,
  parameter int SPILL_W  = 16,
  parameter bit SPILL_EN = 1'b1,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              running,
  input  logic              evtReq,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              evtValid,
  output logic [AC_W-1:0]   evtCycle,
  output logic [AC_W-1:0]   acCount,
  output logic [BX_W-1:0]   bxCount,
  output logic [SPILL_W-1:0] spillCount,
  output logic              bxOvf
);

  localparam logic [BX_W-1:0] BX_MAX = {BX_W{1'b1}};

  // cycle number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  acCount <= '0;
    else if (strb.clearAll)     acCount <= '0;
    else if (strb.advanceCycle) acCount <= acCount + AC_W'(1);
  end

  // bunch-crossing number with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bxCount <= '0;
      bxOvf   <= 1'b0;
    end else if (strb.clearAll || strb.cycleStart) begin
      bxCount <= '0;
      bxOvf   <= 1'b0;
    end else if (strb.bxTick) begin
      if (bxCount == BX_MAX) bxOvf   <= 1'b1;
      else                   bxCount <= bxCount + BX_W'(1);
    end
  end

  // optional spill counter
  generate
    if (SPILL_EN) begin : g_spill
      logic [SPILL_W-1:0] spillReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               spillReg <= '0;
        else if (strb.clearAll)  spillReg <= '0;
        else if (strb.spillRise) spillReg <= spillReg + SPILL_W'(1);
      end
      assign spillCount = spillReg;
    end else begin : g_nospill
      assign spillCount = '0;
    end
  endgenerate

  // event tagging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtCycle <= '0;
    end else begin
      evtValid <= evtReq;
      if (evtReq) evtCycle <= acCount;
    end
  end

  // read-only register view
  always_comb begin
    unique case (rdAddr)
      ADDR_CYCLE:  rdData = DATA_W'(acCount);
      ADDR_BX:     rdData = DATA_W'(bxCount);
      ADDR_SPILL:  rdData = DATA_W'(spillCount);
      default:     rdData = DATA_W'({running, bxOvf});
    endcase
  end

endmodule

// File: rtl/acq_bx_counter.sv
module acq_bx_counter
  import acqcnt_pkg::*;
#(
  parameter int DIV      = 10,
  parameter int AC_W     = 16,
  parameter int BX_W     = 16,
  parameter int SPILL_W  = 16,
  parameter bit SPILL_EN = 1'b1,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostClear,
  input  logic              startAcq,
  input  logic              spillIn,
  input  logic              evtReq,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              evtValid,
  output logic [AC_W-1:0]   evtCycle
);

  ctrlStrobe_t        strb;
  logic               running;
  logic [AC_W-1:0]    acCount;
  logic [BX_W-1:0]    bxCount;
  logic [SPILL_W-1:0] spillCount;
  logic               bxOvf;

  acqcnt_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostClear(hostClear), .startAcq(startAcq),
    .spillIn(spillIn), .strb(strb), .running(running)
  );

  acqcnt_datapath #(
    .AC_W(AC_W), .BX_W(BX_W), .SPILL_W(SPILL_W),
    .SPILL_EN(SPILL_EN), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .running(running), .evtReq(evtReq),
    .rdAddr(rdAddr), .rdData(rdData), .evtValid(evtValid), .evtCycle(evtCycle),
    .acCount(acCount), .bxCount(bxCount), .spillCount(spillCount), .bxOvf(bxOvf)
  );

endmodule

// File: rtl/acqcnt_checker.sv
module acqcnt_checker #(
  parameter int AC_W    = 16,
  parameter int BX_W    = 16,
  parameter int SPILL_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostClear,
  input logic               startAcq,
  input logic               spillIn,
  input logic               evtReq,
  input logic               evtValid,
  input logic [AC_W-1:0]    evtCycle,
  input logic [AC_W-1:0]    acCount,
  input logic [BX_W-1:0]    bxCount,
  input logic [SPILL_W-1:0] spillCount,
  input logic               bxOvf,
  input logic               running
);

  localparam logic [BX_W-1:0] BX_TOP = {BX_W{1'b1}};

  logic prevSpill;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSpill <= 1'b0;
    else       prevSpill <= spillIn;
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostClear |=> (acCount == '0 && bxCount == '0 && spillCount == '0 && !bxOvf && !running));

  assert_first_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startAcq && !hostClear && !running) |=> (running && acCount == '0));

  assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startAcq && !hostClear && running) |=> (acCount == $past(acCount) + AC_W'(1)));

  assert_cycle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!startAcq && !hostClear) |=> $stable(acCount));

  assert_bx_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startAcq && !hostClear) |=> (bxCount == '0 && !bxOvf));

  assert_bx_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!startAcq && !hostClear) |=>
      (bxCount == $past(bxCount) || bxCount == $past(bxCount) + BX_W'(1)));

  assert_bx_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> bxCount == '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    bxOvf |-> bxCount == BX_TOP);

  assert_spill_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!hostClear && spillIn && !prevSpill) |=> (spillCount == $past(spillCount) + SPILL_W'(1)));

  assert_event_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    evtReq |=> (evtValid && evtCycle == $past(acCount)));

  assert_event_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !evtReq |=> !evtValid);

endmodule

bind acq_bx_counter acqcnt_checker #(.AC_W(AC_W), .BX_W(BX_W), .SPILL_W(SPILL_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostClear(hostClear), .startAcq(startAcq),
  .spillIn(spillIn), .evtReq(evtReq), .evtValid(evtValid), .evtCycle(evtCycle),
  .acCount(acCount), .bxCount(bxCount), .spillCount(spillCount),
  .bxOvf(bxOvf), .running(running)
);

// File: tb/acq_bx_counter_test.sv
module acq_bx_counter_test;

  localparam int DIV    = 10;
  localparam int AC_W   = 16;
  localparam int BX_W   = 6;
  localparam int DATA_W = 32;
  localparam int BX_MAX = (1 << BX_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostClear = 1'b0;
  logic startAcq = 1'b0;
  logic spillIn = 1'b0;
  logic evtReq = 1'b0;
  logic [1:0] rdAddr = 2'd0;
  logic [DATA_W-1:0] rdData;
  logic evtValid;
  logic [AC_W-1:0] evtCycle;

  int total = 0;
  int bad = 0;
  int expAc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acq_bx_counter #(.DIV(DIV), .AC_W(AC_W), .BX_W(BX_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .hostClear(hostClear), .startAcq(startAcq),
    .spillIn(spillIn), .evtReq(evtReq), .rdAddr(rdAddr), .rdData(rdData),
    .evtValid(evtValid), .evtCycle(evtCycle)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a falling edge; the read port is combinational
  task automatic readReg(input logic [1:0] a, output longint v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulseStart();
    @(negedge clk) startAcq = 1'b1;
    @(negedge clk) startAcq = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    longint v;
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v);
      check("R1 reset value", v, 0);
    end
    check("R8 no strobe after reset", evtValid, 0);
  endtask

  task automatic testIdleBx();
    longint v;
    waitEdges(35);
    readReg(2'd1, v);
    check("R5 bx idle before first start", v, 0);
  endtask

  task automatic testFirstCycle();
    longint v;
    pulseStart();
    readReg(2'd0, v);
    check("R2 first cycle numbered zero", v, 0);
    readReg(2'd3, v);
    check("R2 running flag set", v, 2);
  endtask

  task automatic testBxCount();
    longint v;
    pulseStart();
    expAc++;
    readReg(2'd0, v);
    check("R3 cycle increments", v, expAc);
    readReg(2'd1, v);
    check("R4 bx restarts at zero", v, 0);
    waitEdges(9);
    readReg(2'd1, v);
    check("R4 bx before first tick", v, 0);
    waitEdges(1);
    readReg(2'd1, v);
    check("R4 bx first tick", v, 1);
    waitEdges(27);
    readReg(2'd1, v);
    check("R4 bx after 37 edges", v, 3);
    // restart mid-period realigns the phase
    pulseStart();
    expAc++;
    waitEdges(9);
    readReg(2'd1, v);
    check("R4 bx phase realigned", v, 0);
    waitEdges(1);
    readReg(2'd1, v);
    check("R4 bx tick after restart", v, 1);
    readReg(2'd0, v);
    check("R3 cycle after third start", v, expAc);
    waitEdges(20);
    readReg(2'd0, v);
    check("R3 cycle holds without start", v, expAc);
  endtask

  task automatic testSaturate();
    longint v;
    pulseStart();
    expAc++;
    waitEdges(BX_MAX * DIV);
    readReg(2'd1, v);
    check("R6 bx reaches max", v, BX_MAX);
    readReg(2'd3, v);
    check("R6 no overflow at max", v, 2);
    waitEdges(DIV + 5);
    readReg(2'd1, v);
    check("R6 bx saturates", v, BX_MAX);
    readReg(2'd3, v);
    check("R6 overflow sticky", v, 3);
    waitEdges(3 * DIV);
    readReg(2'd3, v);
    check("R6 overflow stays", v, 3);
    pulseStart();
    expAc++;
    readReg(2'd3, v);
    check("R6 overflow cleared by start", v, 2);
    readReg(2'd1, v);
    check("R6 bx zero after start", v, 0);
  endtask

  task automatic testSpill();
    longint v;
    longint base;
    readReg(2'd2, base);
    @(negedge clk) spillIn = 1'b1;
    waitEdges(6);
    readReg(2'd2, v);
    check("R7 held spill counted once", v, base + 1);
    spillIn = 1'b0;
    waitEdges(4);
    readReg(2'd2, v);
    check("R7 falling edge not counted", v, base + 1);
    spillIn = 1'b1;
    waitEdges(1);
    spillIn = 1'b0;
    waitEdges(1);
    spillIn = 1'b1;
    waitEdges(2);
    readReg(2'd2, v);
    check("R7 three rising edges", v, base + 3);
    spillIn = 1'b0;
    waitEdges(1);
  endtask

  task automatic testEvent();
    @(negedge clk) evtReq = 1'b1;
    @(negedge clk) evtReq = 1'b0;
    check("R8 strobe valid", evtValid, 1);
    check("R8 strobe carries cycle", evtCycle, expAc);
    @(negedge clk);
    check("R8 strobe one cycle", evtValid, 0);
  endtask

  task automatic testClearPriority();
    longint v;
    @(negedge clk) begin hostClear = 1'b1; startAcq = 1'b1; end
    @(negedge clk) begin hostClear = 1'b0; startAcq = 1'b0; end
    expAc = 0;
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v);
      check("R10 clear wins over start", v, 0);
    end
    waitEdges(25);
    readReg(2'd1, v);
    check("R10 bx idle after clear", v, 0);
    pulseStart();
    readReg(2'd0, v);
    check("R2 first cycle zero after clear", v, 0);
    pulseStart();
    readReg(2'd0, v);
    check("R3 cycle one after clear", v, 1);
    @(negedge clk) hostClear = 1'b1;
    @(negedge clk) hostClear = 1'b0;
    readReg(2'd3, v);
    check("R1 host clear status", v, 0);
    readReg(2'd0, v);
    check("R1 host clear cycle", v, 0);
  endtask

  task automatic testReadMap();
    longint v;
    pulseStart();
    pulseStart();
    pulseStart();
    waitEdges(2 * DIV);
    readReg(2'd0, v);
    check("R9 addr 0 cycle", v, 2);
    readReg(2'd1, v);
    check("R9 addr 1 bx", v, 2);
    readReg(2'd3, v);
    check("R9 addr 3 status", v, 2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    testReset();
    testIdleBx();
    testFirstCycle();
    testBxCount();
    testSaturate();
    testSpill();
    testEvent();
    testClearPriority();
    testReadMap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule